// File: doc/BRIEF.md
# Three-Letter Word Spotter for a Character Stream

This block watches a stream of 8-bit character codes, taking one character on each clock edge where the qualifier is high. It raises a single-bit flag when the last three accepted characters spell the word C, A, R (upper-case codes 0x43, 0x41, 0x52). The block is a four-state Moore machine: nothing seen yet, the first letter seen, the first two letters seen, and the whole word seen.

The flag depends only on the state register, so it goes high in the cycle after the accepting edge of the closing letter. Cycles where the qualifier is low do not move the machine. Partial prefixes restart cleanly: a first letter received in any state starts a new attempt, so streams such as "CCAR" and "CACAR" still produce a hit.

Top module: `car_word_spotter`

## Requirements
- R1: A synchronous active-high reset puts the machine in the nothing-seen state, with `word_hit` at 0 in the cycle after the reset edge.
- R2: `word_hit` is 1 exactly when the last three accepted characters were 0x43, 0x41, 0x52, in that order, and 0 otherwise.
- R3: On an edge where `char_valid` is 0, the state does not change and `word_hit` keeps its value, whatever `char_in` carries.
- R4: An accepted 0x43 moves the machine to the first-letter state from any state, so a repeated or restarted first letter still leads to a hit.
- R5: In the first-letter state an accepted 0x41 moves the machine to the two-letter state.
- R6: In the two-letter state an accepted 0x52 sets `word_hit` to 1 in the next cycle.
- R7: Any accepted character that does not continue the word and is not 0x43 returns the machine to the nothing-seen state.
- R8: After a hit, the next accepted character clears `word_hit`, and a 0x43 there starts a new attempt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| char_in | input | 8 | Character code |
| char_valid | input | 1 | High when `char_in` carries a character to accept |
| word_hit | output | 1 | High while the last three accepted characters form the word |

## Verification
Every result is due one clock after the edge that accepts the character that causes it. The flag changes on that edge and stays put through idle cycles. The bench drives each character on a falling edge and samples `word_hit` one nanosecond after the next rising edge. It compares the flag with a model that keeps the last three accepted characters. The reset result is read the same way, one edge after the reset edge. Hold behaviour is checked over runs of idle cycles, sampled at each edge.

// File: rtl/car_word_pkg.sv
package car_word_pkg;

    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_ONE  = 2'd1,
        ST_TWO  = 2'd2,
        ST_FULL = 2'd3
    } scan_st_e;

    typedef enum logic [1:0] {
        SYM_OTHER  = 2'd0,
        SYM_FIRST  = 2'd1,
        SYM_SECOND = 2'd2,
        SYM_THIRD  = 2'd3
    } sym_e;

    typedef struct packed {
        scan_st_e st;
        logic     hit;
    } scan_reg_t;

endpackage

// File: rtl/car_symbol_decode.sv
module car_symbol_decode
    import car_word_pkg::*;
#(
    parameter int                  CHAR_W      = 8,
    parameter logic [CHAR_W-1:0]   CODE_FIRST  = 8'h43,
    parameter logic [CHAR_W-1:0]   CODE_SECOND = 8'h41,
    parameter logic [CHAR_W-1:0]   CODE_THIRD  = 8'h52
) (
    input  logic [CHAR_W-1:0] ch,
    output sym_e              sym
);
    always_comb begin
        if (ch == CODE_FIRST)       sym = SYM_FIRST;
        else if (ch == CODE_SECOND) sym = SYM_SECOND;
        else if (ch == CODE_THIRD)  sym = SYM_THIRD;
        else                        sym = SYM_OTHER;
    end
endmodule

// File: rtl/car_next_state.sv
module car_next_state
    import car_word_pkg::*;
(
    input  scan_st_e cur,
    input  logic     take,
    input  sym_e     sym,
    output scan_st_e nxt
);
    always_comb begin
        nxt = cur;
        if (take) begin
            if (sym == SYM_FIRST) begin
                // a first letter always opens a fresh attempt
                nxt = ST_ONE;
            end else begin
                unique case (cur)
                    ST_ONE:  nxt = (sym == SYM_SECOND) ? ST_TWO  : ST_NONE;
                    ST_TWO:  nxt = (sym == SYM_THIRD)  ? ST_FULL : ST_NONE;
                    default: nxt = ST_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/car_hit_decode.sv
module car_hit_decode
    import car_word_pkg::*;
(
    input  scan_st_e st,
    output logic     hit
);
    assign hit = (st == ST_FULL);
endmodule

// File: rtl/car_word_spotter.sv
module car_word_spotter
    import car_word_pkg::*;
#(
    parameter int                CHAR_W      = 8,
    parameter logic [CHAR_W-1:0] CODE_FIRST  = 8'h43,
    parameter logic [CHAR_W-1:0] CODE_SECOND = 8'h41,
    parameter logic [CHAR_W-1:0] CODE_THIRD  = 8'h52
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              char_valid,
    output logic              word_hit
);
    sym_e      sym;
    scan_st_e  st_next;
    logic      hit_next;
    scan_reg_t r_d;
    scan_reg_t r_q;

    car_symbol_decode #(
        .CHAR_W     (CHAR_W),
        .CODE_FIRST (CODE_FIRST),
        .CODE_SECOND(CODE_SECOND),
        .CODE_THIRD (CODE_THIRD)
    ) u_sym (
        .ch (char_in),
        .sym(sym)
    );

    car_next_state u_nxt (
        .cur (r_q.st),
        .take(char_valid),
        .sym (sym),
        .nxt (st_next)
    );

    car_hit_decode u_hit (
        .st (st_next),
        .hit(hit_next)
    );

    always_comb begin
        r_d     = r_q;
        r_d.st  = st_next;
        r_d.hit = hit_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st  <= ST_NONE;
            r_q.hit <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign word_hit = r_q.hit;

    // checks
    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst;

    always_ff @(posedge clk) begin
        if (rst_seen_q && !rst) begin
            a_r1_reset_clear: assert (r_q.st == ST_NONE && !word_hit)
                else $error("a_r1_reset_clear");
        end
    end

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !char_valid |=> ($stable(r_q.st) && $stable(word_hit)));

    a_r4_first_restart: assert property (@(posedge clk) disable iff (rst)
        (char_valid && char_in == CODE_FIRST) |=> (r_q.st == ST_ONE && !word_hit));

    a_r5_second_letter: assert property (@(posedge clk) disable iff (rst)
        (char_valid && r_q.st == ST_ONE && char_in == CODE_SECOND) |=> (r_q.st == ST_TWO));

    a_r6_hit_after_third: assert property (@(posedge clk) disable iff (rst)
        (char_valid && r_q.st == ST_TWO && char_in == CODE_THIRD) |=> word_hit);

    a_r7_other_drops: assert property (@(posedge clk) disable iff (rst)
        (char_valid && char_in != CODE_FIRST && char_in != CODE_SECOND && char_in != CODE_THIRD)
        |=> (r_q.st == ST_NONE && !word_hit));

    a_r8_hit_clears: assert property (@(posedge clk) disable iff (rst)
        (word_hit && char_valid) |=> !word_hit);

endmodule

// File: tb/car_word_spotter_bench.sv
module car_word_spotter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] char_in = 8'h00;
    logic       char_valid = 1'b0;
    logic       word_hit;

    int n_tests = 0;
    int n_fail  = 0;
    logic [23:0] hist = 24'h0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    car_word_spotter u_car_word_spotter (
        .clk       (clk),
        .rst       (rst),
        .char_in   (char_in),
        .char_valid(char_valid),
        .word_hit  (word_hit)
    );

    function automatic logic expect_hit(input logic [23:0] h);
        return (h == {8'h43, 8'h41, 8'h52});
    endfunction

    task automatic check(input string tag, input logic exp);
        n_tests++;
        if (word_hit !== exp) begin
            n_fail++;
            $display("FAIL %s: word_hit=%0b expected %0b at %0t", tag, word_hit, exp, $time);
        end
    endtask

    // drive on falling edge, sample 1 ns after the accepting rising edge
    task automatic step(input logic [7:0] c, input logic v, input string tag);
        @(negedge clk);
        char_in    = c;
        char_valid = v;
        if (v) hist = {hist[15:0], c};
        @(posedge clk);
        #1;
        check(tag, expect_hit(hist));
    endtask

    task automatic word(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) step(s[i], 1'b1, tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        char_valid = 1'b0;
        hist = 24'h0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(tag, 1'b0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: expired, run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4821));
        repeat (2) @(posedge clk);
        do_reset("R1 reset state");

        word("CAR", "R6 plain word");
        step(8'h52, 1'b0, "R3 hold after hit");
        step(8'h43, 1'b0, "R3 hold after hit");
        step(8'h5A, 1'b1, "R8 hit clears");
        word("CCAR", "R4 repeated first");
        step(8'h43, 1'b1, "R8 restart after hit");
        word("AR", "R8 restart completes");
        word("CACAR", "R4 overlapping restart");
        word("CAXR", "R7 other char breaks");
        word("CARR", "R7 extra third letter");
        step(8'h43, 1'b1, "R5 split word");
        step(8'h41, 1'b0, "R3 idle mid word");
        step(8'h41, 1'b1, "R5 second letter");
        step(8'h00, 1'b0, "R3 idle mid word");
        step(8'h52, 1'b1, "R2 split completes");
        word("AR", "R2 without first");
        word("CA", "R5 prefix");
        do_reset("R1 reset mid word");
        step(8'h52, 1'b1, "R1 no hit after reset");
        word("car", "R7 lower case ignored");

        for (int i = 0; i < 20000; i++) begin
            logic [7:0] c;
            int pick;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1, 2: c = 8'h43;
                3, 4:    c = 8'h41;
                5, 6:    c = 8'h52;
                default: c = 8'($urandom);
            endcase
            step(c, ($urandom_range(0, 3) != 0), "R2 random stream");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule